// File: doc/BRIEF.md
# Polled Character Input Port

This block sits on a simple processor bus and lets software fetch single characters from a slow input device by polling. Software writes the start command (the value 1) into the status/control register. The block then raises a one-cycle start strobe toward the device and marks itself busy. When the device presents a character with its valid strobe, the block latches it, clears busy and sets the ready flag. Software polls the status byte and tests its most significant bit, which acts as a sign bit: it keeps looping while that bit is 0, then reads the character from the data register.

The data register sits at the base address and the status/control register at the base address plus one. A build-time parameter picks one of two decode variants. In the memory-space variant, the registers respond to the ordinary memory read and write strobes at full-width addresses. In the port-space variant, they respond only to dedicated I/O read and write strobes, and only the low bits of the address form a small port number.

Top module: `charport_regif`

## Requirements
- R1: A write of the value 1 to the status address while idle sets busy and drives `dev_start` high for exactly one cycle, beginning with the clock edge that ends the write cycle.
- R2: A write of any value other than 1 to the status address, and any write to the data address, has no effect: no start strobe is issued and the status stays unchanged.
- R3: A start command issued while busy is ignored (no new start strobe), and busy stays set until the device asserts `dev_valid`.
- R4: `dev_valid` while busy latches `dev_char` into the data register, sets ready and clears busy at that clock edge; `dev_valid` while idle changes nothing.
- R5: The status byte has ready in bit DATA_W-1 (the sign bit) and busy in bit 0, with all other bits reading 0. It is read at BASE_ADDR+1, and the data register is read at BASE_ADDR.
- R6: A read of the data address returns the held character in that same cycle, and ready is cleared at the clock edge that ends the read. A read of the status address does not clear ready.
- R7: A read of an address the block does not own returns 0 and changes no state. `bus_rdata` is 0 whenever no read strobe is active.
- R8: In memory-space mode (ISOLATED=0), only `mem_rd` and `mem_wr` are decoded, against the full address, and `io_rd` and `io_wr` are ignored.
- R9: In port-space mode (ISOLATED=1), only `io_rd` and `io_wr` are decoded, with the port number taken from the low PORT_W address bits (upper bits are ignored), and `mem_rd` and `mem_wr` are ignored.
- R10: The synchronous active-high `rst` clears ready, busy, the data register and `dev_start`.
- R11: When `dev_valid` (while busy) and a data-address read occur in the same cycle, the read returns the old character, and afterwards ready is set and the new character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address (port number in its low PORT_W bits in port-space mode) |
| bus_wdata | input | DATA_W | Write data |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_rd | input | 1 | I/O port read strobe |
| io_wr | input | 1 | I/O port write strobe |
| bus_rdata | output | DATA_W | Read data, combinational from the address and strobes |
| dev_start | output | 1 | One-cycle request to the device to fetch a character |
| dev_valid | input | 1 | Device strobe: `dev_char` holds a character |
| dev_char | input | DATA_W | Character from the device |

## Verification
Two instances, one per decode variant, share the same bus and device stimulus, so each access pattern is seen as owned by one instance and foreign to the other. Full polling transactions (start, busy polls, capture, data read, ready cleared) are mixed with start commands while busy, non-1 command values, writes to the data address, device strobes while idle, and reads at neighbouring and aliased addresses. These patterns separate a correct decode from one that ignores the strobe type, the address width or the written value. A same-cycle capture and data read shows whether capture takes priority over the read-clear of ready, and a mid-transaction reset shows that all state is cleared.

// File: rtl/charport_pkg.sv
package charport_pkg;
   // Which register a bus access selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_STAT = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/charport_dec.sv
module charport_dec
   import charport_pkg::*;
#(
   parameter int               ADDR_W    = 16,
   parameter int               PORT_W    = 8,
   parameter bit               ISOLATED  = 1'b0,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0204
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              io_rd,
   input  logic              io_wr,
   output reg_sel_e          rd_sel,
   output reg_sel_e          wr_sel
);
   logic rd_en, wr_en, hit_d, hit_s;

   generate
      if (ISOLATED) begin : g_port_space
         localparam logic [PORT_W-1:0] P_DATA = BASE_ADDR[PORT_W-1:0];
         localparam logic [PORT_W-1:0] P_STAT = P_DATA + 1'b1;
         logic [PORT_W-1:0] port;
         logic              unused_mem;
         assign port       = addr[PORT_W-1:0];
         assign hit_d      = (port == P_DATA);
         assign hit_s      = (port == P_STAT);
         assign rd_en      = io_rd;
         assign wr_en      = io_wr;
         assign unused_mem = ^{mem_rd, mem_wr, addr[ADDR_W-1:PORT_W]};
      end else begin : g_mem_space
         localparam logic [ADDR_W-1:0] A_DATA = BASE_ADDR;
         localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + 1'b1;
         logic unused_io;
         assign hit_d     = (addr == A_DATA);
         assign hit_s     = (addr == A_STAT);
         assign rd_en     = mem_rd;
         assign wr_en     = mem_wr;
         assign unused_io = ^{io_rd, io_wr};
      end
   endgenerate

   always_comb begin
      rd_sel = SEL_NONE;
      wr_sel = SEL_NONE;
      if (rd_en && hit_d)      rd_sel = SEL_DATA;
      else if (rd_en && hit_s) rd_sel = SEL_STAT;
      if (wr_en && hit_d)      wr_sel = SEL_DATA;
      else if (wr_en && hit_s) wr_sel = SEL_STAT;
   end
endmodule

// File: rtl/charport_core.sv
module charport_core
   import charport_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int START_CMD = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  reg_sel_e          rd_sel,
   input  reg_sel_e          wr_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dev_valid,
   input  logic [DATA_W-1:0] dev_char,
   output logic              dev_start,
   output logic              busy,
   output logic              ready,
   output logic [DATA_W-1:0] data
);
   localparam logic [DATA_W-1:0] CMD = START_CMD[DATA_W-1:0];

   logic start_ok, capture, drain;

   assign start_ok = (wr_sel == SEL_STAT) && (wdata == CMD) && !busy;
   assign capture  = dev_valid && busy;
   assign drain    = (rd_sel == SEL_DATA);

   always_ff @(posedge clk) begin
      if (rst) begin
         dev_start <= 1'b0;
         busy      <= 1'b0;
         ready     <= 1'b0;
         data      <= '0;
      end else begin
         dev_start <= start_ok;
         if (capture) begin
            data  <= dev_char;
            ready <= 1'b1;
            busy  <= 1'b0;
         end else if (start_ok) begin
            busy  <= 1'b1;
            ready <= 1'b0;
         end else if (drain) begin
            ready <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/charport_rdmux.sv
module charport_rdmux
   import charport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  reg_sel_e          rd_sel,
   input  logic              busy,
   input  logic              ready,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] status;
   assign status = {ready, {(DATA_W-2){1'b0}}, busy};

   always_comb begin
      unique case (rd_sel)
         SEL_DATA: rdata = data;
         SEL_STAT: rdata = status;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/charport_regif.sv
module charport_regif
   import charport_pkg::*;
#(
   parameter int               ADDR_W    = 16,
   parameter int               DATA_W    = 8,
   parameter int               PORT_W    = 8,
   parameter bit               ISOLATED  = 1'b0,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0204,
   parameter int               START_CMD = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              dev_start,
   input  logic              dev_valid,
   input  logic [DATA_W-1:0] dev_char
);
   // Elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (PORT_W < 1 || PORT_W >= ADDR_W) begin : g_bad_port_w
      $error("PORT_W must be between 1 and ADDR_W-1");
   end
   if (ISOLATED && (BASE_ADDR[PORT_W-1:0] == {PORT_W{1'b1}})) begin : g_bad_port_base
      $error("status port does not fit in the port space");
   end
   if (!ISOLATED && (BASE_ADDR == {ADDR_W{1'b1}})) begin : g_bad_mem_base
      $error("status address does not fit in the address space");
   end
   if (START_CMD < 0 || START_CMD >= (1 << DATA_W)) begin : g_bad_cmd
      $error("START_CMD must fit in DATA_W bits");
   end

   reg_sel_e          rd_sel, wr_sel;
   logic              busy_w, ready_w;
   logic [DATA_W-1:0] data_w;

   charport_dec #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .ISOLATED(ISOLATED), .BASE_ADDR(BASE_ADDR)
   ) u_dec (
      .addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .io_rd(io_rd), .io_wr(io_wr), .rd_sel(rd_sel), .wr_sel(wr_sel)
   );

   charport_core #(
      .DATA_W(DATA_W), .START_CMD(START_CMD)
   ) u_core (
      .clk(clk), .rst(rst), .rd_sel(rd_sel), .wr_sel(wr_sel), .wdata(bus_wdata),
      .dev_valid(dev_valid), .dev_char(dev_char), .dev_start(dev_start),
      .busy(busy_w), .ready(ready_w), .data(data_w)
   );

   charport_rdmux #(
      .DATA_W(DATA_W)
   ) u_rdmux (
      .rd_sel(rd_sel), .busy(busy_w), .ready(ready_w), .data(data_w), .rdata(bus_rdata)
   );
endmodule

// File: rtl/charport_regif_chk.sv
module charport_regif_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              busy,
   input logic              ready,
   input logic [DATA_W-1:0] data,
   input logic              dev_start,
   input logic              dev_valid,
   input logic [DATA_W-1:0] dev_char
);
   logic rst_seen = 1'b0;
   always @(posedge clk) rst_seen <= rst;

   // R10: the edge after a reset cycle leaves everything cleared
   always @(negedge clk) begin
      if (rst_seen) begin
         assert_reset_clear_R10: assert (!busy && !ready && !dev_start && data == '0);
      end
   end

   // R1: the start strobe only appears together with busy
   assert_start_busy_R1: assert property (@(posedge clk) disable iff (rst)
      dev_start |-> busy);

   // R3: a start strobe never repeats on the next cycle
   assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
      dev_start |=> !dev_start);

   // R3: busy holds until the device strobes a character
   assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (busy && !dev_valid) |=> busy);

   // R4: capture while busy sets ready, clears busy and holds the character
   assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
      (busy && dev_valid) |=> (ready && !busy && data == $past(dev_char)));
endmodule

bind charport_regif charport_regif_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .busy(busy_w), .ready(ready_w), .data(data_w),
   .dev_start(dev_start), .dev_valid(dev_valid), .dev_char(dev_char)
);

// File: tb/charport_regif_tb.sv
module charport_regif_tb;
   localparam logic [15:0] MD = 16'h0204, MS = 16'h0205;
   localparam logic [15:0] ID = 16'h0030, IS = 16'h0031;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic mem_rd = 0, mem_wr = 0, io_rd = 0, io_wr = 0;
   logic dev_valid = 0;
   logic [7:0] dev_char = '0;
   logic [7:0] rdata_m, rdata_i;
   logic start_m, start_i;

   always #5 clk = ~clk;

   charport_regif #(.ISOLATED(1'b0), .BASE_ADDR(MD)) u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
      .bus_rdata(rdata_m), .dev_start(start_m), .dev_valid(dev_valid), .dev_char(dev_char));

   charport_regif #(.ISOLATED(1'b1), .BASE_ADDR(ID)) u_dut_io (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
      .bus_rdata(rdata_i), .dev_start(start_i), .dev_valid(dev_valid), .dev_char(dev_char));

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model, index 0 = memory, 1 = port
   bit       m_ready[2], m_busy[2], m_start[2];
   bit [7:0] m_data[2];
   bit       model_on = 0;

   function automatic bit owns(input int i, input logic [15:0] a, input int off);
      if (i == 0) return a == (MD + 16'(off));
      return a[7:0] == (ID[7:0] + 8'(off));
   endfunction

   function automatic bit rd_act(input int i);
      return (i == 0) ? mem_rd : io_rd;
   endfunction

   function automatic bit wr_act(input int i);
      return (i == 0) ? mem_wr : io_wr;
   endfunction

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (rst) begin
            m_ready[i] = 0; m_busy[i] = 0; m_start[i] = 0; m_data[i] = 0;
         end else begin
            bit go;
            go = wr_act(i) && owns(i, bus_addr, 1) && bus_wdata == 8'h01 && !m_busy[i];
            m_start[i] = go;
            if (dev_valid && m_busy[i]) begin
               m_data[i] = dev_char; m_ready[i] = 1; m_busy[i] = 0;
            end else if (go) begin
               m_busy[i] = 1; m_ready[i] = 0;
            end else if (rd_act(i) && owns(i, bus_addr, 0)) begin
               m_ready[i] = 0;
            end
         end
      end
      model_on = 1;
   end

   always @(negedge clk) begin
      if (model_on && !done) begin
         for (int i = 0; i < 2; i++) begin
            logic [7:0] exp_rd, act_rd;
            logic act_st;
            exp_rd = 8'h00;
            if (rd_act(i) && owns(i, bus_addr, 0))      exp_rd = m_data[i];
            else if (rd_act(i) && owns(i, bus_addr, 1)) exp_rd = {m_ready[i], 6'b0, m_busy[i]};
            act_rd = (i == 0) ? rdata_m : rdata_i;
            act_st = (i == 0) ? start_m : start_i;
            check(act_rd == exp_rd, "model rdata R5 R6 R7", act_rd, exp_rd);
            check(act_st == m_start[i], "model dev_start R1 R3", act_st, m_start[i]);
         end
      end
   end

   // ---------------- bus tasks
   task automatic rd(input bit io, input logic [15:0] a, output logic [7:0] vm, output logic [7:0] vi);
      @(posedge clk); #1;
      bus_addr = a; mem_rd = !io; io_rd = io;
      @(negedge clk);
      vm = rdata_m; vi = rdata_i;
      @(posedge clk); #1;
      mem_rd = 0; io_rd = 0;
   endtask

   task automatic wr(input bit io, input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; mem_wr = !io; io_wr = io;
      @(posedge clk); #1;
      mem_wr = 0; io_wr = 0;
   endtask

   task automatic dev(input logic [7:0] c);
      @(posedge clk); #1;
      dev_valid = 1; dev_char = c;
      @(posedge clk); #1;
      dev_valid = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] vm, vi;
      repeat (3) @(posedge clk);
      #1 rst = 0;

      // reset state
      rd(0, MS, vm, vi);
      check(vm == 8'h00, "R10 status after reset", vm, 0);
      check(vi == 8'h00, "R9 port instance ignores mem strobe", vi, 0);
      check(start_m == 0, "R10 no start after reset", start_m, 0);

      // full polled transaction, memory space
      wr(0, MS, 8'h01);
      check(start_m == 1, "R1 start pulse", start_m, 1);
      check(start_i == 0, "R9 port instance ignores mem write", start_i, 0);
      @(posedge clk); #1;
      check(start_m == 0, "R1 pulse lasts one cycle", start_m, 0);
      rd(0, MS, vm, vi);
      check(vm == 8'h01, "R5 busy in bit 0", vm, 8'h01);
      wr(0, MS, 8'h01);
      check(start_m == 0, "R3 start while busy ignored", start_m, 0);
      rd(0, MS, vm, vi);
      check(vm == 8'h01, "R3 still busy", vm, 8'h01);
      dev(8'hA5);
      rd(0, MS, vm, vi);
      check(vm == 8'h80, "R4 ready in sign bit", vm, 8'h80);
      rd(0, MS, vm, vi);
      check(vm == 8'h80, "R6 status read keeps ready", vm, 8'h80);
      rd(0, MD, vm, vi);
      check(vm == 8'hA5, "R6 data read", vm, 8'hA5);
      rd(0, MS, vm, vi);
      check(vm == 8'h00, "R6 ready cleared by data read", vm, 0);

      // unowned addresses
      rd(0, 16'h0206, vm, vi);
      check(vm == 8'h00, "R7 unowned above", vm, 0);
      rd(0, 16'h0203, vm, vi);
      check(vm == 8'h00, "R7 unowned below", vm, 0);
      rd(1, MS, vm, vi);
      check(vm == 8'h00, "R8 io strobe ignored by memory instance", vm, 0);
      wr(1, MS, 8'h01);
      check(start_m == 0, "R8 io write ignored by memory instance", start_m, 0);

      // ignored writes
      wr(0, MS, 8'h03);
      check(start_m == 0, "R2 non-1 command ignored", start_m, 0);
      wr(0, MD, 8'h01);
      check(start_m == 0, "R2 write to data ignored", start_m, 0);
      rd(0, MS, vm, vi);
      check(vm == 8'h00, "R2 status unchanged", vm, 0);
      dev(8'h11);
      rd(0, MS, vm, vi);
      check(vm == 8'h00, "R4 idle strobe ignored", vm, 0);
      rd(0, MD, vm, vi);
      check(vm == 8'hA5, "R4 data kept on idle strobe", vm, 8'hA5);

      // port space
      wr(1, IS, 8'h01);
      check(start_i == 1, "R9 port start", start_i, 1);
      check(start_m == 0, "R8 memory instance idle", start_m, 0);
      rd(1, IS, vm, vi);
      check(vi == 8'h01, "R9 port status busy", vi, 8'h01);
      dev(8'h3C);
      rd(1, 16'h5531, vm, vi);
      check(vi == 8'h80, "R9 upper address bits ignored", vi, 8'h80);
      rd(0, IS, vm, vi);
      check(vi == 8'h00, "R9 mem strobe at port ignored", vi, 0);
      rd(1, ID, vm, vi);
      check(vi == 8'h3C, "R9 port data", vi, 8'h3C);
      check(vm == 8'h00, "R8 memory instance quiet", vm, 0);

      // capture and data read in the same cycle
      wr(0, MS, 8'h01);
      @(posedge clk); #1;
      dev_valid = 1; dev_char = 8'h5A; bus_addr = MD; mem_rd = 1;
      @(negedge clk);
      check(rdata_m == 8'hA5, "R11 read returns old char", rdata_m, 8'hA5);
      @(posedge clk); #1;
      dev_valid = 0; mem_rd = 0;
      rd(0, MS, vm, vi);
      check(vm == 8'h80, "R11 capture wins over clear", vm, 8'h80);
      rd(0, MD, vm, vi);
      check(vm == 8'h5A, "R11 new char held", vm, 8'h5A);

      // reset in the middle of activity
      wr(0, MS, 8'h01);
      dev(8'h77);
      wr(1, IS, 8'h01);
      @(posedge clk); #1 rst = 1;
      @(posedge clk); #1 rst = 0;
      rd(0, MS, vm, vi);
      check(vm == 8'h00, "R10 ready cleared", vm, 0);
      rd(0, MD, vm, vi);
      check(vm == 8'h00, "R10 data cleared", vm, 0);
      rd(1, IS, vm, vi);
      check(vi == 8'h00, "R10 busy cleared", vi, 0);

      repeat (2) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule